// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Tracker

This block sits on the peripheral side of a bidirectional parallel-port link. It follows the host's negotiation handshake to work out which transfer mode is in force. Compatibility mode is the fallback and has no request code of its own. The block watches four host control lines (nStrobe, nAutoFd, nSelectIn, nInit) and the 8-bit data bus. A negotiation opens when nSelectIn is high and nAutoFd is low. The block then captures the request value on the data bus when nStrobe falls, and commits the mode when nStrobe is released.

A new mode can only be negotiated from compatibility mode. The host returns the link to compatibility mode by pulling nSelectIn low, and this works from any state. Once ECP mode is active, every edge on nInit is reported as a change of data direction. The block drives a handshake acknowledge for as long as a negotiation is open. It also gives one-cycle pulses when a negotiation starts, when a request value is rejected, and when the ECP direction reverses.

Top module: `ppt_mode_tracker`

## Requirements
- R1: After reset, mode_o is 0 (compatibility), and ack_o, neg_start_o, reject_o and ecp_rev_o are all 0.
- R2: Every host input passes through a two-flop synchronizer and then an edge stage. A change on a host input driven between two clock edges first affects the outputs right after the third rising edge that follows the change.
- R3: While the block is idle in compatibility mode, the condition (nSelectIn high and nAutoFd low) becoming true gives a one-cycle neg_start_o pulse. ack_o then rises and stays high until the negotiation commits, is rejected or is terminated.
- R4: The data bus is captured on the falling edge of nStrobe. Data changes at any other time are ignored. When nStrobe rises, the captured value is decoded and mode_o is set: 0x00 selects nibble (mode_o=1), 0x01 selects byte (mode_o=2) and 0x10 selects ECP (mode_o=3).
- R5: Any other captured value gives a one-cycle reject_o pulse. mode_o stays 0, ack_o drops, and the block returns to idle.
- R6: A negotiation condition that arises while a non-compatibility mode is active gives no neg_start_o and leaves mode_o unchanged.
- R7: A falling edge on nSelectIn in any non-idle state (negotiation open or a mode active) sets mode_o to 0 and ack_o to 0.
- R8: While mode_o is 3, every edge of nInit (rising or falling) gives one ecp_rev_o pulse. In every other mode, nInit edges give no pulse.
- R9: neg_start_o, reject_o and ecp_rev_o each last exactly one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nstrobe_i | input | 1 | Host strobe line, asynchronous |
| nautofd_i | input | 1 | Host auto-feed / host-ack line, asynchronous |
| nselectin_i | input | 1 | Host select-in line, asynchronous |
| ninit_i | input | 1 | Host init line, asynchronous |
| data_i | input | 8 | Parallel data bus, asynchronous |
| mode_o | output | 2 | Active mode: 0 compatibility, 1 nibble, 2 byte, 3 ECP |
| ack_o | output | 1 | Peripheral acknowledge, high while a negotiation is open |
| neg_start_o | output | 1 | One-cycle pulse when a negotiation opens |
| reject_o | output | 1 | One-cycle pulse when a request value is not recognised |
| ecp_rev_o | output | 1 | One-cycle pulse on each ECP direction reversal |

## Verification
The assertions check several properties on every cycle. The acknowledge is only ever high while the mode is compatibility. A negotiation pulse only follows an idle compatibility state. A direction-reversal pulse only appears in ECP mode. The three pulses are single-cycle and mutually exclusive. Termination always reaches compatibility mode, and an active mode holds steady unless nSelectIn falls. Other behaviours can only be shown by the bench's scenarios, where a behavioural model is compared against the design on every clock: the three-edge synchronizer latency, the capture of data on the strobe edge rather than at release, the decoding of each request code, and that negotiation attempts inside an active mode are ignored.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 4;
  // control vector bit positions
  localparam int CTL_STB  = 0;
  localparam int CTL_AFD  = 1;
  localparam int CTL_SEL  = 2;
  localparam int CTL_INIT = 3;
  // host idle levels: nInit high, nSelectIn low, nAutoFd high, nStrobe high
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1011;

  localparam logic [DATA_W-1:0] XREQ_NIBBLE = 8'h00;
  localparam logic [DATA_W-1:0] XREQ_BYTE   = 8'h01;
  localparam logic [DATA_W-1:0] XREQ_ECP    = 8'h10;

  typedef enum logic [1:0] {
    MODE_COMPAT = 2'd0,
    MODE_NIBBLE = 2'd1,
    MODE_BYTE   = 2'd2,
    MODE_ECP    = 2'd3
  } ppt_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_STB = 2'd1,
    ST_WAIT_REL = 2'd2,
    ST_ACTIVE   = 2'd3
  } ppt_state_e;

  typedef struct packed {
    logic      ok;
    ppt_mode_e mode;
  } ppt_dec_t;

  function automatic ppt_dec_t decode_req(input logic [DATA_W-1:0] v);
    ppt_dec_t d;
    d.ok   = 1'b1;
    d.mode = MODE_COMPAT;
    unique case (v)
      XREQ_NIBBLE: d.mode = MODE_NIBBLE;
      XREQ_BYTE:   d.mode = MODE_BYTE;
      XREQ_ECP:    d.mode = MODE_ECP;
      default:     d.ok   = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ppt_sync.sv
module ppt_sync #(
  parameter int               W       = 4,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ppt_edge.sv
module ppt_edge #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= cur_i;
  end

  assign prev_o = prev_q;
  assign rise_o = cur_i & ~prev_q;
  assign fall_o = ~cur_i & prev_q;
endmodule

// File: rtl/ppt_neg_fsm.sv
module ppt_neg_fsm
  import ppt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTL_W-1:0]  cur_i,
  input  logic [CTL_W-1:0]  prev_i,
  input  logic [CTL_W-1:0]  rise_i,
  input  logic [CTL_W-1:0]  fall_i,
  input  logic [DATA_W-1:0] data_i,
  output ppt_mode_e         mode_o,
  output logic              ack_o,
  output logic              neg_start_o,
  output logic              reject_o,
  output logic              ecp_rev_o
);
  ppt_state_e        state_q, state_d;
  ppt_mode_e         mode_q, mode_d;
  logic [DATA_W-1:0] lat_q, lat_d;
  logic              neg_q, neg_d, rej_q, rej_d, rev_q, rev_d;
  logic              req_cur, req_prev, req_rise, term;
  ppt_dec_t          dec;

  assign req_cur  = cur_i[CTL_SEL]  & ~cur_i[CTL_AFD];
  assign req_prev = prev_i[CTL_SEL] & ~prev_i[CTL_AFD];
  assign req_rise = req_cur & ~req_prev;
  assign term     = (state_q != ST_IDLE) & fall_i[CTL_SEL];
  assign dec      = decode_req(lat_q);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    lat_d   = lat_q;
    neg_d   = 1'b0;
    rej_d   = 1'b0;
    rev_d   = 1'b0;
    if (term) begin
      state_d = ST_IDLE;
      mode_d  = MODE_COMPAT;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_rise) begin
          state_d = ST_WAIT_STB;
          neg_d   = 1'b1;
        end
        ST_WAIT_STB: if (fall_i[CTL_STB]) begin
          lat_d   = data_i;
          state_d = ST_WAIT_REL;
        end
        ST_WAIT_REL: if (rise_i[CTL_STB]) begin
          if (dec.ok) begin
            mode_d  = dec.mode;
            state_d = ST_ACTIVE;
          end else begin
            rej_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
        ST_ACTIVE: if (mode_q == MODE_ECP && (rise_i[CTL_INIT] | fall_i[CTL_INIT]))
          rev_d = 1'b1;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_COMPAT;
      lat_q   <= '0;
      neg_q   <= 1'b0;
      rej_q   <= 1'b0;
      rev_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      lat_q   <= lat_d;
      neg_q   <= neg_d;
      rej_q   <= rej_d;
      rev_q   <= rev_d;
    end
  end

  assign mode_o      = mode_q;
  assign ack_o       = (state_q == ST_WAIT_STB) | (state_q == ST_WAIT_REL);
  assign neg_start_o = neg_q;
  assign reject_o    = rej_q;
  assign ecp_rev_o   = rev_q;

  AST_ACK_IN_COMPAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> mode_q == MODE_COMPAT); // R3
  AST_NEG_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_q |-> ($past(state_q) == ST_IDLE && $past(mode_q) == MODE_COMPAT)); // R6
  AST_REJECT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_q |-> (mode_q == MODE_COMPAT && state_q == ST_IDLE)); // R5
  AST_TERM_COMPAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && fall_i[CTL_SEL]) |=> (mode_q == MODE_COMPAT && !ack_o)); // R7
  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && !fall_i[CTL_SEL]) |=> $stable(mode_q)); // R6
  AST_REV_ONLY_ECP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_q |-> mode_q == MODE_ECP); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({neg_q, rej_q, rev_q})); // R9
  AST_NEG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_q |=> !neg_q); // R9
  AST_REJ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_q |=> !rej_q); // R9
endmodule

// File: rtl/ppt_mode_tracker.sv
module ppt_mode_tracker
  import ppt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nstrobe_i,
  input  logic              nautofd_i,
  input  logic              nselectin_i,
  input  logic              ninit_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [1:0]        mode_o,
  output logic              ack_o,
  output logic              neg_start_o,
  output logic              reject_o,
  output logic              ecp_rev_o
);
  localparam int BUS_W = CTL_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {{DATA_W{1'b0}}, CTL_IDLE};

  logic [BUS_W-1:0]  raw_bus, sync_bus;
  logic [CTL_W-1:0]  ctl_cur, ctl_prev, ctl_rise, ctl_fall;
  logic [DATA_W-1:0] data_sync;
  ppt_mode_e         mode_e;

  always_comb begin
    raw_bus                     = '0;
    raw_bus[CTL_STB]            = nstrobe_i;
    raw_bus[CTL_AFD]            = nautofd_i;
    raw_bus[CTL_SEL]            = nselectin_i;
    raw_bus[CTL_INIT]           = ninit_i;
    raw_bus[BUS_W-1:CTL_W]      = data_i;
  end

  ppt_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_bus),
    .q_o   (sync_bus)
  );

  assign ctl_cur   = sync_bus[CTL_W-1:0];
  assign data_sync = sync_bus[BUS_W-1:CTL_W];

  ppt_edge #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cur_i (ctl_cur),
    .prev_o(ctl_prev),
    .rise_o(ctl_rise),
    .fall_o(ctl_fall)
  );

  ppt_neg_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_i      (ctl_cur),
    .prev_i     (ctl_prev),
    .rise_i     (ctl_rise),
    .fall_i     (ctl_fall),
    .data_i     (data_sync),
    .mode_o     (mode_e),
    .ack_o      (ack_o),
    .neg_start_o(neg_start_o),
    .reject_o   (reject_o),
    .ecp_rev_o  (ecp_rev_o)
  );

  assign mode_o = mode_e;
endmodule

// File: tb/ppt_mode_tracker_bench.sv
module ppt_mode_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b1, afd = 1'b1, sel = 1'b0, init = 1'b1;
  logic [7:0] dat = 8'h00;
  logic [1:0] mode;
  logic ack, neg, rej, rev;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk; // 125 MHz

  ppt_mode_tracker u_ppt_mode_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .nstrobe_i(stb), .nautofd_i(afd), .nselectin_i(sel), .ninit_i(init),
    .data_i(dat), .mode_o(mode), .ack_o(ack),
    .neg_start_o(neg), .reject_o(rej), .ecp_rev_o(rev)
  );

  // behavioural reference: entries {data, init, sel, afd, stb}
  logic [11:0] hist[$];
  int   m_st = 0, m_mode = 0;
  bit   m_ack, m_neg, m_rej, m_rev;
  logic [7:0] m_lat;

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [11:0] c, p;
    if (!rst_n) begin
      hist = {12'h00B, 12'h00B, 12'h00B};
      m_st = 0; m_mode = 0; m_ack = 0; m_neg = 0; m_rej = 0; m_rev = 0; m_lat = 0;
    end else begin
      c = hist[1];
      p = hist[0];
      m_neg = 0; m_rej = 0; m_rev = 0;
      if (m_st != 0 && p[2] && !c[2]) begin
        m_st = 0; m_mode = 0;
      end else begin
        case (m_st)
          0: if ((c[2] && !c[1]) && !(p[2] && !p[1])) begin m_st = 1; m_neg = 1; end
          1: if (p[0] && !c[0]) begin m_lat = c[11:4]; m_st = 2; end
          2: if (!p[0] && c[0]) begin
               if (m_lat == 8'h00)      begin m_mode = 1; m_st = 3; end
               else if (m_lat == 8'h01) begin m_mode = 2; m_st = 3; end
               else if (m_lat == 8'h10) begin m_mode = 3; m_st = 3; end
               else begin m_rej = 1; m_st = 0; end
             end
          default: if (m_mode == 3 && c[3] != p[3]) m_rev = 1;
        endcase
      end
      hist.push_back({dat, init, sel, afd, stb});
      void'(hist.pop_front());
      m_ack = (m_st == 1 || m_st == 2);
      #2;
      cmp("mode_o", int'(mode), m_mode);
      cmp("ack_o", int'(ack), int'(m_ack));
      cmp("neg_start_o", int'(neg), int'(m_neg));
      cmp("reject_o", int'(rej), int'(m_rej));
      cmp("ecp_rev_o", int'(rev), int'(m_rev));
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic negotiate(input logic [7:0] v);
    @(negedge clk); dat = v; sel = 1'b1; afd = 1'b0;
    wait_n(5); stb = 1'b0;
    wait_n(5); stb = 1'b1;
    wait_n(5); afd = 1'b1;
    wait_n(4);
  endtask

  task automatic terminate();
    @(negedge clk); sel = 1'b0; afd = 1'b1;
    wait_n(5);
  endtask

  initial begin
    int pulses;
    wait_n(4);
    tag = "R1";
    cmp("reset mode_o", int'(mode), 0);
    cmp("reset ack_o", int'(ack), 0);
    cmp("reset pulses", int'({neg, rej, rev}), 0);
    rst_n = 1'b1;
    wait_n(3);

    // R2 latency, then byte request
    tag = "R2";
    dat = 8'h01; sel = 1'b1; afd = 1'b0;
    @(negedge clk); @(negedge clk);
    cmp("neg_start_o before third edge", int'(neg), 0);
    @(negedge clk);
    cmp("neg_start_o after third edge", int'(neg), 1);
    tag = "R3";
    cmp("ack_o during negotiation", int'(ack), 1);
    wait_n(3); stb = 1'b0; wait_n(5); stb = 1'b1; wait_n(5); afd = 1'b1; wait_n(3);
    tag = "R4";
    cmp("byte mode_o", int'(mode), 2);
    tag = "R7";
    terminate();
    cmp("mode_o after termination", int'(mode), 0);

    // nibble, then ignored requests and nInit edges
    tag = "R4";
    negotiate(8'h00);
    cmp("nibble mode_o", int'(mode), 1);
    tag = "R6";
    pulses = 0;
    for (int i = 0; i < 3; i++) begin
      afd = 1'b0; wait_n(4); pulses += 0; afd = 1'b1; wait_n(4);
    end
    init = 1'b0; wait_n(4); init = 1'b1; wait_n(4);
    cmp("nibble mode_o kept", int'(mode), 1);
    tag = "R7";
    terminate();

    // ECP with direction reversals
    tag = "R8";
    negotiate(8'h10);
    cmp("ECP mode_o", int'(mode), 3);
    pulses = 0;
    init = 1'b0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += int'(rev); end
    init = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += int'(rev); end
    cmp("ecp_rev_o pulse count", pulses, 2);
    tag = "R7";
    terminate();

    // rejected values
    tag = "R5";
    pulses = 0;
    @(negedge clk); dat = 8'h55; sel = 1'b1; afd = 1'b0;
    wait_n(5); stb = 1'b0; wait_n(5); stb = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += int'(rej); end
    cmp("reject_o pulse count", pulses, 1);
    cmp("mode_o after reject", int'(mode), 0);
    cmp("ack_o after reject", int'(ack), 0);
    afd = 1'b1; terminate();
    negotiate(8'h11);
    cmp("mode_o after 0x11", int'(mode), 0);
    terminate();

    // termination while negotiation is open
    tag = "R7";
    @(negedge clk); dat = 8'h10; sel = 1'b1; afd = 1'b0;
    wait_n(5);
    cmp("ack_o open", int'(ack), 1);
    terminate();
    cmp("ack_o after abort", int'(ack), 0);
    cmp("mode_o after abort", int'(mode), 0);

    // data captured on strobe fall, not release
    tag = "R4";
    @(negedge clk); dat = 8'h10; sel = 1'b1; afd = 1'b0;
    wait_n(5); stb = 1'b0; wait_n(5); dat = 8'h00; wait_n(3); stb = 1'b1; wait_n(5);
    cmp("mode_o uses value at strobe fall", int'(mode), 3);
    tag = "R9";
    afd = 1'b1;
    terminate();
    wait_n(3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule